// File: doc/BRIEF.md
# Gray-Scale Calibration Loop Sequencer

This block is the digital half of six drive-calibration loops for a three-colour display output stage. Three loops trim the gain of the red, green and blue drives and three trim their dark-level offsets. Each loop keeps its current setting in an 8-bit latch. The analog side turns each latch into a current and compares the measured cathode feedback against a reference. That comparison reaches the block as two decision bits: one says the error is above an upper threshold, the other says it is below a lower threshold.

A field-start pulse opens a calibration window. Each of the next six line strobes handles one latch. The three gain latches are handled first, in red, green, blue order, and the three dark latches follow in the same colour order. For each line, a single shared up/down counter is backloaded from the addressed latch. It then moves at most one code according to the comparator bits, with a deadband where it holds. Finally it is loaded back into the latch. During the window, the drives that are not being measured are held off. A host register port presets the latches and sets brightness, contrast and the gain limit thresholds. The host can also freeze the loops once they have settled. Two flags tell the host when any gain setting has left the programmed range.

Top module: `gray_cal_top`

## Requirements
- R1: After reset, every latch reads 0x80, brightness and contrast read 0x80, chanOff is 0, and both limit flags are 0 (lower limit 0x10, upper limit 0xF0).
- R2: A host write stores hostWdata in the register at hostAddr, visible on the next cycle. The addresses are: 0 to 5 for latches (0 gain red, 1 gain green, 2 gain blue, 3 dark red, 4 dark green, 5 dark blue), 6 for control (bit 0 = freeze), 7 for brightness, 8 for contrast, 9 for the lower limit and 10 for the upper limit.
- R3: After fieldStart, the six following lineStrobe pulses handle latches 0,1,2,3,4,5 in that order. A lineStrobe outside the window changes no latch.
- R4: On a handled line, the addressed latch increases by one if only cmpAbove is high and decreases by one if only cmpBelow is high. The new value is visible three clock cycles after the cycle in which lineStrobe is sampled.
- R5: On a handled line where cmpAbove and cmpBelow are both low or both high, the latch is unchanged.
- R6: A latch at 0xFF does not increase and a latch at 0x00 does not decrease; neither wraps.
- R7: While the window is open, chanOff bit c (0 red, 1 green, 2 blue) is 1 for every colour other than the colour of the latch currently addressed. chanOff is 0 once the sixth line's write-back is done and at all other times outside the window.
- R8: With freeze set, handled lines leave every latch unchanged.
- R9: A write to brightness or contrast clears freeze.
- R10: limitHigh is 1 when any gain latch (0 to 2) is above the upper limit. limitLow is 1 when any gain latch is below the lower limit. Dark latches do not affect either flag.
- R11: A fieldStart during an open window restarts the sequence at latch 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fieldStart | input | 1 | One-cycle pulse that opens the calibration window |
| lineStrobe | input | 1 | One-cycle pulse at the start of each line |
| cmpAbove | input | 1 | Error above the upper threshold (count up) |
| cmpBelow | input | 1 | Error below the lower threshold (count down) |
| hostWe | input | 1 | Host register write enable |
| hostAddr | input | 4 | Host register address |
| hostWdata | input | 8 | Host write data |
| chanOff | output | 3 | Per-colour drive disable, bit 0 red, bit 2 blue |
| latchBus | output | 48 | Six latch values, latch i in bits [8i+7:8i] |
| brightness | output | 8 | Brightness register |
| contrast | output | 8 | Contrast register |
| limitHigh | output | 1 | A gain latch is above the upper limit |
| limitLow | output | 1 | A gain latch is below the lower limit |

## Verification
A latch result is due on the fourth falling edge after lineStrobe is driven. That edge follows the sampling edge and then the backload, evaluate and load edges. Host register results, the limit flags and the chanOff change after fieldStart are all due on the first falling edge after the write or pulse. The driver holds the comparator bits steady for the whole line and waits exactly those edges before it pushes the expected values. The monitor compares every queued item 1 ns after that falling edge, well before the next rising edge. For this reason no expectation is compared early or against a later cycle.

// File: rtl/gray_cal_pkg.sv
package gray_cal_pkg;

  localparam int NUM_COLOURS = 3;
  localparam int NUM_SLOTS   = 2 * NUM_COLOURS;
  localparam int SLOT_W      = $clog2(NUM_SLOTS + 1);
  localparam int COLOUR_W    = $clog2(NUM_COLOURS);

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_BACK,
    PH_EVAL,
    PH_LOAD
  } phase_e;

  typedef struct packed {
    logic              backload;
    logic              evaluate;
    logic              load;
    logic [SLOT_W-1:0] slot;
  } seq_strobe_t;

  // Gain latches occupy the first NUM_COLOURS slots, dark latches the rest.
  function automatic logic [COLOUR_W-1:0] colourOf(input logic [SLOT_W-1:0] s);
    if (s >= SLOT_W'(NUM_COLOURS))
      return COLOUR_W'(s - SLOT_W'(NUM_COLOURS));
    else
      return COLOUR_W'(s);
  endfunction

endpackage

// File: rtl/gray_cal_ctrl.sv
module gray_cal_ctrl
  import gray_cal_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fieldStart,
  input  logic                   lineStrobe,
  output seq_strobe_t            strobe,
  output logic [NUM_COLOURS-1:0] chanOff,
  output logic                   windowOn
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  phase_e              phase;
  logic [SLOT_W-1:0]   lineIdx;
  logic                active;
  logic [COLOUR_W-1:0] curColour;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      lineIdx <= '0;
      active  <= 1'b0;
    end else if (fieldStart) begin
      phase   <= PH_IDLE;
      lineIdx <= '0;
      active  <= 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: if (lineStrobe && active) phase <= PH_BACK;
        PH_BACK: phase <= PH_EVAL;
        PH_EVAL: phase <= PH_LOAD;
        PH_LOAD: begin
          phase   <= PH_IDLE;
          lineIdx <= lineIdx + SLOT_W'(1);
          if (lineIdx == LAST_SLOT) active <= 1'b0;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.backload = (phase == PH_BACK);
    strobe.evaluate = (phase == PH_EVAL);
    strobe.load     = (phase == PH_LOAD);
    strobe.slot     = lineIdx;
  end

  assign curColour = colourOf(lineIdx);
  assign windowOn  = active;

  for (genvar c = 0; c < NUM_COLOURS; c++) begin : g_chanOff
    assign chanOff[c] = active && (curColour != COLOUR_W'(c));
  end

endmodule

// File: rtl/gray_cal_dp.sv
module gray_cal_dp
  import gray_cal_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  seq_strobe_t                 strobe,
  input  logic                        cmpAbove,
  input  logic                        cmpBelow,
  input  logic                        hostWe,
  input  logic [ADDR_W-1:0]           hostAddr,
  input  logic [DATA_W-1:0]           hostWdata,
  output logic [NUM_SLOTS*DATA_W-1:0] latchBus,
  output logic [DATA_W-1:0]           brightness,
  output logic [DATA_W-1:0]           contrast,
  output logic                        limitHigh,
  output logic                        limitLow,
  output logic [DATA_W-1:0]           loopCount,
  output logic                        loopsFrozen
);

  localparam logic [DATA_W-1:0] CODE_MAX  = '1;
  localparam logic [DATA_W-1:0] CODE_MID  = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] LIM_LO_RST = DATA_W'(16);
  localparam logic [DATA_W-1:0] LIM_HI_RST = CODE_MAX - DATA_W'(15);
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = ADDR_W'(NUM_SLOTS);
  localparam logic [ADDR_W-1:0] ADDR_BRT   = ADDR_W'(NUM_SLOTS + 1);
  localparam logic [ADDR_W-1:0] ADDR_CON   = ADDR_W'(NUM_SLOTS + 2);
  localparam logic [ADDR_W-1:0] ADDR_LLO   = ADDR_W'(NUM_SLOTS + 3);
  localparam logic [ADDR_W-1:0] ADDR_LHI   = ADDR_W'(NUM_SLOTS + 4);

  logic [DATA_W-1:0] latchQ [NUM_SLOTS];
  logic [DATA_W-1:0] selLatch;
  logic [DATA_W-1:0] stepCount;
  logic [DATA_W-1:0] limLo;
  logic [DATA_W-1:0] limHi;

  // Per-slot latches: the sequencer write-back has priority over the host.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_latch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        latchQ[s] <= CODE_MID;
      else if (strobe.load && (strobe.slot == SLOT_W'(s)))
        latchQ[s] <= loopCount;
      else if (hostWe && (hostAddr == ADDR_W'(s)))
        latchQ[s] <= hostWdata;
    end
    assign latchBus[s*DATA_W +: DATA_W] = latchQ[s];
  end

  always_comb begin
    selLatch = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (strobe.slot == SLOT_W'(s)) selLatch = latchQ[s];
  end

  // Deadband step with saturation at both ends of the code range.
  always_comb begin
    stepCount = loopCount;
    if (cmpAbove && !cmpBelow && (loopCount != CODE_MAX))
      stepCount = loopCount + DATA_W'(1);
    else if (cmpBelow && !cmpAbove && (loopCount != '0))
      stepCount = loopCount - DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      loopCount <= '0;
    else if (strobe.backload)
      loopCount <= selLatch;
    else if (strobe.evaluate && !loopsFrozen)
      loopCount <= stepCount;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loopsFrozen <= 1'b0;
      brightness  <= CODE_MID;
      contrast    <= CODE_MID;
      limLo       <= LIM_LO_RST;
      limHi       <= LIM_HI_RST;
    end else if (hostWe) begin
      unique case (hostAddr)
        ADDR_CTRL: loopsFrozen <= hostWdata[0];
        ADDR_BRT: begin
          brightness  <= hostWdata;
          loopsFrozen <= 1'b0;
        end
        ADDR_CON: begin
          contrast    <= hostWdata;
          loopsFrozen <= 1'b0;
        end
        ADDR_LLO: limLo <= hostWdata;
        ADDR_LHI: limHi <= hostWdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    limitHigh = 1'b0;
    limitLow  = 1'b0;
    for (int g = 0; g < NUM_COLOURS; g++) begin
      if (latchQ[g] > limHi) limitHigh = 1'b1;
      if (latchQ[g] < limLo) limitLow  = 1'b1;
    end
  end

endmodule

// File: rtl/gray_cal_top.sv
module gray_cal_top
  import gray_cal_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fieldStart,
  input  logic                        lineStrobe,
  input  logic                        cmpAbove,
  input  logic                        cmpBelow,
  input  logic                        hostWe,
  input  logic [ADDR_W-1:0]           hostAddr,
  input  logic [DATA_W-1:0]           hostWdata,
  output logic [NUM_COLOURS-1:0]      chanOff,
  output logic [NUM_SLOTS*DATA_W-1:0] latchBus,
  output logic [DATA_W-1:0]           brightness,
  output logic [DATA_W-1:0]           contrast,
  output logic                        limitHigh,
  output logic                        limitLow
);

  seq_strobe_t       strobe;
  logic              windowOn;
  logic [DATA_W-1:0] loopCount;
  logic              loopsFrozen;

  gray_cal_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fieldStart (fieldStart),
    .lineStrobe (lineStrobe),
    .strobe     (strobe),
    .chanOff    (chanOff),
    .windowOn   (windowOn)
  );

  gray_cal_dp #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .cmpAbove    (cmpAbove),
    .cmpBelow    (cmpBelow),
    .hostWe      (hostWe),
    .hostAddr    (hostAddr),
    .hostWdata   (hostWdata),
    .latchBus    (latchBus),
    .brightness  (brightness),
    .contrast    (contrast),
    .limitHigh   (limitHigh),
    .limitLow    (limitLow),
    .loopCount   (loopCount),
    .loopsFrozen (loopsFrozen)
  );

endmodule

// File: rtl/gray_cal_chk.sv
module gray_cal_chk
  import gray_cal_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input seq_strobe_t                 strobe,
  input logic                        windowOn,
  input logic [DATA_W-1:0]           loopCount,
  input logic                        loopsFrozen,
  input logic                        cmpAbove,
  input logic                        cmpBelow,
  input logic [NUM_COLOURS-1:0]      chanOff,
  input logic [NUM_SLOTS*DATA_W-1:0] latchBus
);

  localparam logic [DATA_W-1:0] CODE_MAX = '1;

  AST_BACKLOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.backload |=> loopCount == $past(latchBus[strobe.slot*DATA_W +: DATA_W])); // R4

  AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> latchBus[$past(strobe.slot)*DATA_W +: DATA_W] == $past(loopCount)); // R4

  AST_STEP_UP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.evaluate && !loopsFrozen && cmpAbove && !cmpBelow && (loopCount != CODE_MAX)
    |=> loopCount == $past(loopCount) + DATA_W'(1)); // R4

  AST_DEADBAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.evaluate && (cmpAbove == cmpBelow) |=> $stable(loopCount)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.evaluate && cmpAbove && (loopCount == CODE_MAX) |=> loopCount == CODE_MAX); // R6

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.evaluate && cmpBelow && (loopCount == '0) |=> loopCount == '0); // R6

  AST_CHAN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    windowOn |-> $countones(chanOff) == NUM_COLOURS - 1); // R7

  AST_CHAN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !windowOn |-> chanOff == '0); // R7

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.evaluate && loopsFrozen |=> $stable(loopCount)); // R8

endmodule

bind gray_cal_top gray_cal_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .strobe      (strobe),
  .windowOn    (windowOn),
  .loopCount   (loopCount),
  .loopsFrozen (loopsFrozen),
  .cmpAbove    (cmpAbove),
  .cmpBelow    (cmpBelow),
  .chanOff     (chanOff),
  .latchBus    (latchBus)
);

// File: tb/gray_cal_top_bench.sv
module gray_cal_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fieldStart = 1'b0;
  logic        lineStrobe = 1'b0;
  logic        cmpAbove = 1'b0;
  logic        cmpBelow = 1'b0;
  logic        hostWe = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic [7:0]  hostWdata = '0;
  logic [2:0]  chanOff;
  logic [47:0] latchBus;
  logic [7:0]  brightness;
  logic [7:0]  contrast;
  logic        limitHigh;
  logic        limitLow;

  always #5 clk = ~clk;

  gray_cal_top u_gray_cal_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .fieldStart (fieldStart),
    .lineStrobe (lineStrobe),
    .cmpAbove   (cmpAbove),
    .cmpBelow   (cmpBelow),
    .hostWe     (hostWe),
    .hostAddr   (hostAddr),
    .hostWdata  (hostWdata),
    .chanOff    (chanOff),
    .latchBus   (latchBus),
    .brightness (brightness),
    .contrast   (contrast),
    .limitHigh  (limitHigh),
    .limitLow   (limitLow)
  );

  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 1'b0;

  // Reference model, written from the requirements.
  logic [7:0] mLatch [6];
  logic [7:0] mBright, mContrast, mLimLo, mLimHi;
  bit         mFrozen, mActive;
  int         mSlot;

  function automatic logic [7:0] actualOf(int sel);
    case (sel)
      0, 1, 2, 3, 4, 5: return latchBus[sel*8 +: 8];
      6:       return {5'b0, chanOff};
      7:       return {7'b0, limitHigh};
      8:       return {7'b0, limitLow};
      9:       return brightness;
      default: return contrast;
    endcase
  endfunction

  function automatic logic [7:0] expectedOf(int sel);
    logic hi = 1'b0;
    logic lo = 1'b0;
    for (int g = 0; g < 3; g++) begin
      if (mLatch[g] > mLimHi) hi = 1'b1;
      if (mLatch[g] < mLimLo) lo = 1'b1;
    end
    case (sel)
      0, 1, 2, 3, 4, 5: return mLatch[sel];
      6: begin
        if (mActive && mSlot < 6) return {5'b0, 3'b111 & ~(3'b001 << (mSlot % 3))};
        else return 8'h00;
      end
      7:       return {7'b0, hi};
      8:       return {7'b0, lo};
      9:       return mBright;
      default: return mContrast;
    endcase
  endfunction

  task automatic pushAll(input string req);
    for (int s = 0; s < 11; s++) begin
      item_t it;
      it.sel = s;
      it.exp = expectedOf(s);
      it.req = req;
      q.push_back(it);
    end
  endtask

  // Monitor: compares queued expectations 1 ns after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        act = actualOf(it.sel);
        nChecks++;
        if (act !== it.exp) begin
          nFails++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic hostWrite(input logic [3:0] addr, input logic [7:0] data);
    hostWe = 1'b1; hostAddr = addr; hostWdata = data;
    @(negedge clk);
    hostWe = 1'b0;
    case (addr)
      0, 1, 2, 3, 4, 5: mLatch[addr] = data;
      6:  mFrozen = data[0];
      7:  begin mBright = data;   mFrozen = 1'b0; end
      8:  begin mContrast = data; mFrozen = 1'b0; end
      9:  mLimLo = data;
      10: mLimHi = data;
      default: ;
    endcase
  endtask

  task automatic startField();
    fieldStart = 1'b1;
    @(negedge clk);
    fieldStart = 1'b0;
    mActive = 1'b1;
    mSlot = 0;
  endtask

  task automatic runLine(input logic up, input logic down);
    cmpAbove = up; cmpBelow = down;
    lineStrobe = 1'b1;
    @(negedge clk);
    lineStrobe = 1'b0;
    repeat (3) @(negedge clk);
    if (mActive) begin
      if (!mFrozen) begin
        if (up && !down && mLatch[mSlot] != 8'hFF) mLatch[mSlot] = mLatch[mSlot] + 8'd1;
        else if (down && !up && mLatch[mSlot] != 8'h00) mLatch[mSlot] = mLatch[mSlot] - 8'd1;
      end
      mSlot++;
      if (mSlot == 6) mActive = 1'b0;
    end
    cmpAbove = 1'b0; cmpBelow = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 6; s++) mLatch[s] = 8'h80;
    mBright = 8'h80; mContrast = 8'h80; mLimLo = 8'h10; mLimHi = 8'hF0;
    mFrozen = 1'b0; mActive = 1'b0; mSlot = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pushAll("R1");

    // R2: host presets
    hostWrite(4'd0, 8'hFF); pushAll("R2");
    hostWrite(4'd1, 8'h50); pushAll("R2");
    hostWrite(4'd3, 8'h00); pushAll("R2");
    hostWrite(4'd9, 8'h20); pushAll("R2");

    // R3 R4 R5 R6 R7: one full field with mixed decisions
    startField(); pushAll("R7");
    runLine(1'b1, 1'b0); pushAll("R6");
    runLine(1'b0, 1'b1); pushAll("R4");
    runLine(1'b0, 1'b0); pushAll("R5");
    runLine(1'b0, 1'b1); pushAll("R6");
    runLine(1'b1, 1'b0); pushAll("R4");
    runLine(1'b1, 1'b1); pushAll("R5");
    pushAll("R7");
    runLine(1'b1, 1'b0); pushAll("R3");

    // R8: freeze
    hostWrite(4'd6, 8'h01); pushAll("R8");
    startField();
    for (int l = 0; l < 6; l++) begin
      runLine(1'b1, 1'b0); pushAll("R8");
    end

    // R9: brightness write releases freeze, contrast too
    hostWrite(4'd7, 8'h33); pushAll("R9");
    startField();
    for (int l = 0; l < 6; l++) begin
      runLine(1'b0, 1'b1); pushAll("R9");
    end
    hostWrite(4'd6, 8'h01);
    hostWrite(4'd8, 8'hC4); pushAll("R9");
    startField();
    runLine(1'b1, 1'b0); pushAll("R9");

    // R10: limit flags, gain only
    hostWrite(4'd0, 8'h60);
    hostWrite(4'd1, 8'h60);
    hostWrite(4'd2, 8'h60); pushAll("R10");
    hostWrite(4'd10, 8'h70); pushAll("R10");
    hostWrite(4'd4, 8'hFF); pushAll("R10");
    hostWrite(4'd2, 8'h71); pushAll("R10");
    hostWrite(4'd5, 8'h00); pushAll("R10");
    hostWrite(4'd9, 8'h61); pushAll("R10");
    hostWrite(4'd1, 8'h10); pushAll("R10");

    // R11: restart mid-window
    startField(); pushAll("R11");
    runLine(1'b1, 1'b0);
    runLine(1'b1, 1'b0); pushAll("R11");
    startField(); pushAll("R11");
    runLine(1'b0, 1'b1); pushAll("R11");
    runLine(1'b1, 1'b0); pushAll("R11");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule